// File: doc/BRIEF.md
# Reloading Tick Timer

The block is a two-stage countdown timer for a single processor core. The first stage is a prescaler that divides the core clock by a programmable tick period and emits a one-cycle tick each time it wraps. The second stage is an interrupt counter that counts those ticks down from a programmed value. When it expires it raises a pending flag, and that flag drives the interrupt line through an enable mask. In interval mode the interrupt counter reloads and keeps firing until software clears the start bits. Without interval mode it stops at zero, which gives one-shot behaviour.

Software reaches the timer through a plain single-cycle write port and a combinational read port. The register map is: 0 control, 1 tick period, 2 interrupt count, 3 interrupt enable, 4 pending status, 5 write acknowledge, 6 live tick counter (read only), 7 live interrupt counter (read only). Writes to the control, tick-period and interrupt-count registers are confirmed by sticky acknowledge bits, which software clears by writing 1. There is no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `tick_timer`

## Requirements
- R1: After reset, every readable register and both live counters read 0, and `irq` is low.
- R2: The interrupt counter decrements only while control bit 0 (timer start) and control bit 1 (interrupt start) are both 1. With timer start alone, no ticks are counted. With interrupt start alone, the prescaler is stopped.
- R3: With tick period T (a value of 0 acts as 1) and interrupt count N, the pending flag is set N*T clock cycles after the clock edge that writes the control start bits.
- R4: A write to the interrupt-count register with bit 31 set loads bits 30:0 into both the live counter and the reload value. A write with bit 31 clear has no effect on either. The largest count is 0x7FFFFFFF.
- R5: With control bit 2 (interval mode) clear, the interrupt counter reads 0 after it expires and raises no further interrupts.
- R6: Write-acknowledge bit 0 is set by a tick-period write, bit 1 by an interrupt-count write and bit 3 by a control write, all on the edge of the write. Writing 1 to an acknowledge bit clears only that bit. Writes to other registers set no acknowledge bit.
- R7: With interval mode set, the counter reloads on expiry and the pending flag is set again every N*T cycles.
- R8: `irq` is high exactly when the pending flag is set and interrupt-enable bit 0 is 1. A masked expiry still sets the pending flag.
- R9: Clearing the start bits freezes the interrupt counter at its current value and leaves the pending flag unchanged.
- R10: Pending is status bit 0. Writing 1 clears it, writing 0 has no effect, and an expiry in the same cycle as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt, pending AND enable |

## Verification
The hardest situation to reach is the stop in the middle of a count. The interrupt counter must freeze after exactly as many ticks as fit before the stop write, and that number depends on the phase of the prescaler. The stimulus starts a long count with a tick period of 2 and stops it at a cycle offset recorded by the bench. The bench then predicts the frozen value as the start count minus half the elapsed edges and reads it back twice. Interval-mode repetition is reached by clearing the pending flag between expiries, while a scoreboard holds the predicted interrupt cycle stamps.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 3'd0,
    REG_TICK_BUF = 3'd1,
    REG_INT_BUF  = 3'd2,
    REG_INT_EN   = 3'd3,
    REG_STATUS   = 3'd4,
    REG_WSTAT    = 3'd5,
    REG_TICK_CNT = 3'd6,
    REG_INT_CNT  = 3'd7
  } reg_addr_e;

  // control bit positions
  localparam int CTRL_TSTART   = 0;
  localparam int CTRL_ISTART   = 1;
  localparam int CTRL_INTERVAL = 2;
  localparam int CTRL_W        = 3;

  // write-acknowledge bit positions
  localparam int WS_TICK_BUF = 0;
  localparam int WS_INT_BUF  = 1;
  localparam int WS_CTRL     = 3;
  localparam int WS_W        = 4;

  // load-request flag inside an interrupt-count write
  localparam int LOAD_REQ_BIT = DATA_W - 1;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TICK_W-1:0] period,
  output logic              tick,
  output logic [TICK_W-1:0] count
);
  localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

  logic wrap;
  assign wrap = (count <= ONE);
  assign tick = run && wrap;

  // While stopped the counter sits at the period, so a start begins a full period.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!run) begin
      count <= period;
    end else if (wrap) begin
      count <= period;
    end else begin
      count <= count - ONE;
    end
  end
endmodule

// File: rtl/tick_int_counter.sv
module tick_int_counter #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             interval,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step   = run && tick && (count != '0) && !load;
  assign expire = step && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else if (load) begin
      count  <= load_val;
      reload <= load_val;
    end else if (step) begin
      if (count == ONE) begin
        count <= interval ? reload : '0;
      end else begin
        count <= count - ONE;
      end
    end
  end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_addr_e         wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  reg_addr_e         rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              expire,
  input  logic [TICK_W-1:0] tick_cnt,
  input  logic [CNT_W-1:0]  int_cnt,
  input  logic [CNT_W-1:0]  int_reload,
  output logic              tmr_run,
  output logic              int_run,
  output logic              interval,
  output logic [TICK_W-1:0] tick_buf,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              pending,
  output logic              int_en,
  output logic [WS_W-1:0]   wstat
);
  logic [CTRL_W-1:0] ctrl;
  logic [WS_W-1:0]   ack_set;
  logic [WS_W-1:0]   ack_clr;
  logic              wr_ctrl, wr_tick, wr_int, wr_en_r, wr_stat, wr_ws;

  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign wr_tick = wr_en && (wr_addr == REG_TICK_BUF);
  assign wr_int  = wr_en && (wr_addr == REG_INT_BUF);
  assign wr_en_r = wr_en && (wr_addr == REG_INT_EN);
  assign wr_stat = wr_en && (wr_addr == REG_STATUS);
  assign wr_ws   = wr_en && (wr_addr == REG_WSTAT);

  assign tmr_run  = ctrl[CTRL_TSTART];
  assign int_run  = ctrl[CTRL_TSTART] && ctrl[CTRL_ISTART];
  assign interval = ctrl[CTRL_INTERVAL];

  assign load     = wr_int && wr_data[LOAD_REQ_BIT];
  assign load_val = wr_data[CNT_W-1:0];

  always_comb begin
    ack_set              = '0;
    ack_set[WS_TICK_BUF] = wr_tick;
    ack_set[WS_INT_BUF]  = wr_int;
    ack_set[WS_CTRL]     = wr_ctrl;
    ack_clr              = wr_ws ? wr_data[WS_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      tick_buf <= '0;
      int_en   <= 1'b0;
      pending  <= 1'b0;
      wstat    <= '0;
    end else begin
      if (wr_ctrl) ctrl     <= wr_data[CTRL_W-1:0];
      if (wr_tick) tick_buf <= wr_data[TICK_W-1:0];
      if (wr_en_r) int_en   <= wr_data[0];
      // expiry wins over a simultaneous clear
      if (expire) begin
        pending <= 1'b1;
      end else if (wr_stat && wr_data[0]) begin
        pending <= 1'b0;
      end
      wstat <= (wstat & ~ack_clr) | ack_set;
    end
  end

  always_comb begin
    unique case (rd_addr)
      REG_CTRL:     rd_data = DATA_W'(ctrl);
      REG_TICK_BUF: rd_data = DATA_W'(tick_buf);
      REG_INT_BUF:  rd_data = DATA_W'(int_reload);
      REG_INT_EN:   rd_data = DATA_W'(int_en);
      REG_STATUS:   rd_data = DATA_W'(pending);
      REG_WSTAT:    rd_data = DATA_W'(wstat);
      REG_TICK_CNT: rd_data = DATA_W'(tick_cnt);
      REG_INT_CNT:  rd_data = DATA_W'(int_cnt);
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic              tmr_run, int_run, interval, load, pending, int_en;
  logic              tick, expire;
  logic [TICK_W-1:0] tick_buf, tick_cnt;
  logic [CNT_W-1:0]  load_val, int_cnt, int_reload;
  logic [WS_W-1:0]   wstat;

  tick_timer_regs #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (reg_addr_e'(wr_addr)),
    .wr_data    (wr_data),
    .rd_addr    (reg_addr_e'(rd_addr)),
    .rd_data    (rd_data),
    .expire     (expire),
    .tick_cnt   (tick_cnt),
    .int_cnt    (int_cnt),
    .int_reload (int_reload),
    .tmr_run    (tmr_run),
    .int_run    (int_run),
    .interval   (interval),
    .tick_buf   (tick_buf),
    .load       (load),
    .load_val   (load_val),
    .pending    (pending),
    .int_en     (int_en),
    .wstat      (wstat)
  );

  tick_prescaler #(.TICK_W(TICK_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .period (tick_buf),
    .tick   (tick),
    .count  (tick_cnt)
  );

  tick_int_counter #(.CNT_W(CNT_W)) u_icnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (int_run),
    .tick     (tick),
    .interval (interval),
    .load     (load),
    .load_val (load_val),
    .count    (int_cnt),
    .reload   (int_reload),
    .expire   (expire)
  );

  assign irq = pending && int_en;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick,
  input logic              load,
  input logic              expire,
  input logic              int_run,
  input logic              interval,
  input logic [CNT_W-1:0]  int_cnt,
  input logic [CNT_W-1:0]  int_reload,
  input logic              pending,
  input logic [WS_W-1:0]   wstat,
  input logic              irq
);
  // R2 / R9: without both start bits and without a load the counter holds
  a_r9_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_run && !load) |=> $stable(int_cnt));

  // R3: the counter moves only on ticks
  a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(int_cnt));

  // R5: one-shot expiry leaves the counter at zero
  a_r5_oneshot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !interval) |=> (int_cnt == '0));

  // R7: interval expiry reloads the stored count
  a_r7_interval_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && interval) |=> (int_cnt == $past(int_reload)));

  // R10: an expiry always leaves pending set
  a_r10_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending);

  // R6: a control write is acknowledged on the next cycle
  a_r6_ctrl_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> wstat[WS_CTRL]);

  // R6: acknowledge bit 2 is never used
  a_r6_no_spare_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !wstat[2]);

  // R8: irq cannot be high without pending
  a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pending);

  // R4: a load request changes the counter to the written value
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd2 && wr_data[LOAD_REQ_BIT]) |=> (int_cnt == $past(wr_data[CNT_W-1:0])));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .tick       (tick),
  .load       (load),
  .expire     (expire),
  .int_run    (int_run),
  .interval   (interval),
  .int_cnt    (int_cnt),
  .int_reload (int_reload),
  .pending    (pending),
  .wstat      (wstat),
  .irq        (irq)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic irq_q = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    c = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic expect_irq(input int stamp, input string tag);
    exp_q.push_back(stamp);
    tag_q.push_back(tag);
  endtask

  // monitor: every rising irq must match the next predicted cycle stamp
  always @(negedge clk) begin
    #1;
    if (rst_n && irq && !irq_q) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected irq", cyc, -1);
      end else begin
        string t;
        int    e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, cyc, e);
      end
    end
    irq_q = irq;
  end

  task automatic finish_run();
    chk("R7 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 0);
    end
    chk("R1 irq low", irq, 0);

    // R6 acknowledges
    wr(3'd1, 32'd1, c0);          rd(3'd5, d); chk("R6 tick ack", d, 32'h1);
    wr(3'd2, 32'h8000_0005, c0);  rd(3'd5, d); chk("R6 count ack", d, 32'h3);
    wr(3'd3, 32'd1, c0);          rd(3'd5, d); chk("R6 enable not acked", d, 32'h3);
    wr(3'd5, 32'h1, c0);          rd(3'd5, d); chk("R6 w1c bit0 only", d, 32'h2);
    wr(3'd5, 32'h2, c0);          rd(3'd5, d); chk("R6 w1c bit1", d, 32'h0);

    // R3 / R5 one-shot, T=1 N=5
    wr(3'd0, 32'h3, c0);
    expect_irq(c0 + 5, "R3 one-shot stamp");
    rd(3'd5, d); chk("R6 ctrl ack", d, 32'h8);
    repeat (10) @(negedge clk);
    rd(3'd7, d); chk("R5 counter zero after expiry", d, 0);
    rd(3'd4, d); chk("R5 pending set", d, 1);
    wr(3'd4, 32'h0, c0); rd(3'd4, d); chk("R10 write 0 keeps pending", d, 1);
    wr(3'd4, 32'h1, c0); rd(3'd4, d); chk("R10 write 1 clears", d, 0);
    repeat (10) @(negedge clk);
    rd(3'd4, d); chk("R5 no re-fire", d, 0);
    wr(3'd0, 32'h0, c0);

    // R4 load request flag
    wr(3'd2, 32'h0000_0009, c0);
    rd(3'd7, d); chk("R4 no-flag write ignored counter", d, 0);
    rd(3'd2, d); chk("R4 no-flag write ignored reload", d, 5);
    wr(3'd2, 32'hFFFF_FFFF, c0);
    rd(3'd7, d); chk("R4 max count", d, 32'h7FFF_FFFF);

    // R2 both start bits needed
    wr(3'd2, 32'h8000_0003, c0);
    wr(3'd0, 32'h1, c0);
    repeat (10) @(negedge clk);
    rd(3'd7, d); chk("R2 timer start alone", d, 3);
    wr(3'd0, 32'h2, c0);
    repeat (10) @(negedge clk);
    rd(3'd7, d); chk("R2 interrupt start alone", d, 3);
    wr(3'd0, 32'h0, c0);

    // R7 interval T=3 N=4
    wr(3'd1, 32'd3, c0);
    wr(3'd2, 32'h8000_0004, c0);
    wr(3'd0, 32'h7, c0);
    expect_irq(c0 + 12, "R7 interval first");
    expect_irq(c0 + 24, "R7 interval second");
    expect_irq(c0 + 36, "R7 interval third");
    for (int k = 0; k < 3; k++) begin
      while (!irq) @(negedge clk);
      if (k == 2) wr(3'd0, 32'h0, c1);
      wr(3'd4, 32'h1, c1);
    end
    rd(3'd7, d); chk("R7 reloaded count", d, 4);

    // R8 masking
    wr(3'd3, 32'h0, c0);
    wr(3'd1, 32'd1, c0);
    wr(3'd2, 32'h8000_0002, c0);
    wr(3'd0, 32'h3, c0);
    repeat (6) @(negedge clk);
    chk("R8 masked irq low", irq, 0);
    rd(3'd4, d); chk("R8 masked pending set", d, 1);
    wr(3'd0, 32'h0, c0);
    wr(3'd3, 32'h1, c0);
    expect_irq(c0, "R8 enable raises irq");
    #2;
    chk("R8 irq after enable", irq, 1);
    wr(3'd4, 32'h1, c0);
    chk("R8 irq after clear", irq, 0);

    // R9 stop mid-count, T=2 N=100
    wr(3'd1, 32'd2, c0);
    wr(3'd2, 32'h8000_0064, c0);
    wr(3'd0, 32'h3, c0);
    repeat (21) @(negedge clk);
    wr(3'd0, 32'h0, c1);
    rd(3'd7, d); chk("R9 frozen value", d, 100 - (c1 - c0) / 2);
    repeat (10) @(negedge clk);
    rd(3'd7, d2); chk("R9 stays frozen", d2, d);
    rd(3'd4, d); chk("R9 pending unchanged", d, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule